// File: doc/BRIEF.md
# Two-Read One-Write Integer Register File

This block is the architectural register store for a 32-bit integer core. It holds a bank of general registers that the decode stage reads through two independent, purely combinational read ports, while the writeback stage updates at most one register per clock through a synchronous write port. Register index 0 is a constant zero: it reads as all zeros no matter what has been written to it.

A build-time parameter picks one of two read behaviours. With forwarding off, which is the default, a read of a register that is being written in the same cycle returns the value stored before that clock edge. With forwarding on, the value being written shows up on every read port that addresses that register in the same cycle. Index 0 is never forwarded. An active-high synchronous reset clears every register. The read and write pins are plain control and data pins with no handshake. Every port takes part in every cycle, so there is nothing to back-pressure.

Top module: `regfile_2r1w`

## Requirements
- R1: When `rst` is high at a rising edge of `clk`, every register holds zero after that edge. Reset takes priority over a write in the same cycle.
- R2: When `wr_en` is high at a rising edge, the register at `wr_addr` (if nonzero) takes `wr_data`. From that edge on, both read ports return it for that address.
- R3: When `wr_en` is low at a rising edge, no register changes, whatever `wr_addr` and `wr_data` carry.
- R4: A read of address 0 on either port always returns 0x00000000. Writes to address 0 are discarded.
- R5: The two read ports are independent. Each returns the register chosen by its own address, combinationally and in the same cycle as the address.
- R6: With forwarding off (the default), a read of the address being written in the current cycle returns the value held before the edge.
- R7: With forwarding on, while `wr_en` is high, any read port whose address equals a nonzero `wr_addr` returns `wr_data` in that same cycle.
- R8: With forwarding on, a write to address 0 is not forwarded, and reads of address 0 stay zero.
- R9: A write changes only the addressed register. A read port on another address returns that address's stored value, both during the write cycle and after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Writes and reset act on its rising edge. |
| rst | input | 1 | Active-high synchronous reset. It clears all registers. |
| rd_a_addr | input | 5 | Register index for read port A. |
| rd_a_data | output | 32 | Read port A data, combinational from the index. |
| rd_b_addr | input | 5 | Register index for read port B. |
| rd_b_data | output | 32 | Read port B data, combinational from the index. |
| wr_en | input | 1 | Write enable, sampled at the rising edge. |
| wr_addr | input | 5 | Register index to write. Index 0 is discarded. |
| wr_data | input | 32 | Value to write. |

## Verification
The hardest case to reach from the ports is a read and a write on the same register inside a single cycle. The result depends on which side of the clock edge it is sampled and on the forwarding setting. Writes to index 0 while forwarding is on are an especially tricky variant. The bench runs two copies side by side, one with forwarding off and one with it on, driven by the same pins. During each write cycle it points both read ports at the address being written and samples a few nanoseconds before the edge. The copy with forwarding off must show the old value, and the copy with it on must show the new value, or zero for index 0. Exhaustive sweeps over every address pair then confirm the stored contents after writes, after reset, and after cycles with the enable low and junk on the write pins.

// File: rtl/rf_pkg.sv
package rf_pkg;

  // Read behaviour when a port addresses the register being written.
  typedef enum logic {
    RF_FWD_OFF = 1'b0,
    RF_FWD_ON  = 1'b1
  } rf_fwd_mode_e;

  localparam int unsigned RF_ADDR_W_DEF = 5;
  localparam int unsigned RF_DATA_W_DEF = 32;

endpackage

// File: rtl/rf_wr_decode.sv
// One-hot write select for entries 1..DEPTH-1. Entry 0 has no select line.
module rf_wr_decode #(
  parameter  int unsigned ADDR_W = 5,
  localparam int unsigned DEPTH  = 1 << ADDR_W
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [DEPTH-1:1]  wr_sel
);
  for (genvar i = 1; i < DEPTH; i++) begin : g_sel
    assign wr_sel[i] = wr_en && (wr_addr == ADDR_W'(i));
  end
endmodule

// File: rtl/rf_storage.sv
// Flop array. Entry 0 is a constant zero and has no storage.
module rf_storage #(
  parameter  int unsigned ADDR_W = 5,
  parameter  int unsigned DATA_W = 32,
  localparam int unsigned DEPTH  = 1 << ADDR_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [DEPTH-1:1]              wr_sel,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [DEPTH-1:0][DATA_W-1:0]  cells
);
  assign cells[0] = '0;

  for (genvar i = 1; i < DEPTH; i++) begin : g_cell
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)            q <= '0;
      else if (wr_sel[i]) q <= wr_data;
    end
    assign cells[i] = q;
  end
endmodule

// File: rtl/rf_fwd_match.sv
// Same-cycle forwarding hit for one read port. Index 0 never hits.
module rf_fwd_match #(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              hit
);
  assign hit = wr_en && (wr_addr == rd_addr) && (|wr_addr);
endmodule

// File: rtl/rf_read_port.sv
// Combinational read: a forwarded value if there is a hit, else the stored cell.
module rf_read_port #(
  parameter  int unsigned ADDR_W = 5,
  parameter  int unsigned DATA_W = 32,
  localparam int unsigned DEPTH  = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0]             rd_addr,
  input  logic [DEPTH-1:0][DATA_W-1:0]  cells,
  input  logic                          fwd_hit,
  input  logic [DATA_W-1:0]             fwd_data,
  output logic [DATA_W-1:0]             rd_data
);
  always_comb begin
    if (fwd_hit) rd_data = fwd_data;
    else         rd_data = cells[rd_addr];
  end
endmodule

// File: rtl/regfile_2r1w.sv
module regfile_2r1w #(
  parameter int unsigned          ADDR_W   = rf_pkg::RF_ADDR_W_DEF,
  parameter int unsigned          DATA_W   = rf_pkg::RF_DATA_W_DEF,
  parameter rf_pkg::rf_fwd_mode_e FWD_MODE = rf_pkg::RF_FWD_OFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [ADDR_W-1:0] rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:1]             wr_sel;
  logic [DEPTH-1:0][DATA_W-1:0] cells;
  logic                         hit_a, hit_b;

  rf_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_sel  (wr_sel)
  );

  rf_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .rst     (rst),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .cells   (cells)
  );

  if (FWD_MODE == rf_pkg::RF_FWD_ON) begin : g_fwd
    rf_fwd_match #(.ADDR_W(ADDR_W)) u_match_a (
      .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_a_addr), .hit(hit_a)
    );
    rf_fwd_match #(.ADDR_W(ADDR_W)) u_match_b (
      .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_b_addr), .hit(hit_b)
    );
  end else begin : g_nofwd
    assign hit_a = 1'b0;
    assign hit_b = 1'b0;
  end

  rf_read_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd_a (
    .rd_addr  (rd_a_addr),
    .cells    (cells),
    .fwd_hit  (hit_a),
    .fwd_data (wr_data),
    .rd_data  (rd_a_data)
  );

  rf_read_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd_b (
    .rd_addr  (rd_b_addr),
    .cells    (cells),
    .fwd_hit  (hit_b),
    .fwd_data (wr_data),
    .rd_data  (rd_b_data)
  );
endmodule

// File: rtl/regfile_2r1w_chk.sv
module regfile_2r1w_chk #(
  parameter int unsigned          ADDR_W   = 5,
  parameter int unsigned          DATA_W   = 32,
  parameter rf_pkg::rf_fwd_mode_e FWD_MODE = rf_pkg::RF_FWD_OFF
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] rd_a_addr,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [ADDR_W-1:0] rd_b_addr,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data
);
  localparam bit FWD = (FWD_MODE == rf_pkg::RF_FWD_ON);

  AST_ZERO_A: assert property (@(posedge clk) disable iff (rst)
    (rd_a_addr == '0) |-> (rd_a_data == '0)); // R4
  AST_ZERO_B: assert property (@(posedge clk) disable iff (rst)
    (rd_b_addr == '0) |-> (rd_b_data == '0)); // R4

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!(FWD && wr_en && wr_addr == rd_a_addr && wr_addr != '0) -> rd_a_data == '0)); // R1

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != '0) |=>
      ((rd_a_addr == $past(wr_addr)) && !(FWD && wr_en && wr_addr == rd_a_addr))
        -> (rd_a_data == $past(wr_data))); // R2

  if (FWD) begin : g_fwd_chk
    AST_FWD_A: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr != '0 && rd_a_addr == wr_addr) |-> (rd_a_data == wr_data)); // R7
    AST_FWD_B: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr != '0 && rd_b_addr == wr_addr) |-> (rd_b_data == wr_data)); // R7
  end else begin : g_nofwd_chk
    AST_HOLD_OLD: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_addr == rd_b_addr) |=>
        ((rd_b_addr == $past(rd_b_addr)) -> $stable(rd_b_data))); // R6
  end
endmodule

bind regfile_2r1w regfile_2r1w_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FWD_MODE(FWD_MODE)
) u_chk (
  .clk(clk), .rst(rst),
  .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
  .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/regfile_2r1w_test.sv
`timescale 1ns/1ps
module regfile_2r1w_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  ra, rb, wa;
  logic        we;
  logic [31:0] wd;
  logic [31:0] a_off, b_off, a_on, b_on;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [31:0] model [32];

  always #4 clk = ~clk;

  regfile_2r1w uut (
    .clk(clk), .rst(rst), .rd_a_addr(ra), .rd_a_data(a_off),
    .rd_b_addr(rb), .rd_b_data(b_off), .wr_en(we), .wr_addr(wa), .wr_data(wd)
  );

  regfile_2r1w #(.FWD_MODE(rf_pkg::RF_FWD_ON)) uut_fw (
    .clk(clk), .rst(rst), .rd_a_addr(ra), .rd_a_data(a_on),
    .rd_b_addr(rb), .rd_b_data(b_on), .wr_en(we), .wr_addr(wa), .wr_data(wd)
  );

  function automatic logic [31:0] pat(input int idx, input int round);
    return (32'(idx) * 32'h9E37_79B1) ^ (32'(round) * 32'h0101_0101) ^ 32'h5A00_00C3;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic sweep_pairs(input string req);
    for (int i = 0; i < 32; i++) begin
      for (int j = 0; j < 32; j++) begin
        @(negedge clk);
        ra = 5'(i); rb = 5'(j);
        #1;
        check(req, a_off, model[i]); check(req, b_off, model[j]);
        check(req, a_on,  model[i]); check(req, b_on,  model[j]);
      end
    end
  endtask

  task automatic write_round(input int round, input bit odd_only);
    for (int i = 0; i < 32; i++) begin
      if (!odd_only || (i % 2 == 1)) begin
        @(negedge clk);
        we = 1'b1; wa = 5'(i); wd = pat(i, round);
        ra = 5'(i); rb = 5'((i + 3) % 32);
        #1;
        check("R6 old value without forwarding", a_off, model[i]);
        check("R7/R8 forwarded value", a_on, (i == 0) ? 32'h0 : pat(i, round));
        check("R9 other port during write", b_off, model[(i + 3) % 32]);
        check("R9 other port during write fwd", b_on, model[(i + 3) % 32]);
        @(posedge clk);
        if (i != 0) model[i] = pat(i, round);
      end
    end
    @(negedge clk);
    we = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 32'h0;
    rst = 1'b1; we = 1'b0; wa = '0; wd = '0; ra = '0; rb = '0;
    @(negedge clk);
    // R1: a write held during reset must be overridden
    we = 1'b1; wa = 5'd9; wd = 32'hDEAD_BEEF;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0; we = 1'b0;
    sweep_pairs("R1 reset clears");

    // R2, R4, R6, R7, R8, R9: first write round over every index
    write_round(1, 1'b0);
    sweep_pairs("R2/R4/R5 stored contents");

    // R3: enable low with junk on the write pins
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      we = 1'b0; wa = 5'(i); wd = ~pat(i, 7);
    end
    sweep_pairs("R3 disabled write ignored");

    // R9: overwrite only odd registers, evens must keep round 1
    write_round(2, 1'b1);
    sweep_pairs("R9 only addressed register changes");

    // R1: reset after data present
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = 32'h0;
    sweep_pairs("R1 reset after writes");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule